// File: doc/BRIEF.md
# Serial Flash Security Register Programmer

This block is the slave side of a serial flash that serves the command for programming three one-time security registers of 256 bytes each. It samples the serial clock, chip select and serial input into the system clock domain. It decodes a single-byte opcode, a three-byte address and a stream of data bytes. When chip select rises on a clean byte boundary, it starts a self-timed program cycle whose length is a parameter counted in system clocks.

During the program cycle, the bytes collected in a staging buffer are merged into the addressed register. Merging can only clear bits. The block also serves the write-enable command that arms programming, and the status read that reports the busy flag and the write-enable latch. A neighbouring read-command handler reads the register contents through a plain synchronous read port. The per-register permanent lock bits come from elsewhere in the device.

Top module: `secreg_prog`

## Requirements
- R1: After reset, `wip`, `wel` and `so` are 0, and every byte of all three registers reads 0xFF.
- R2: Opcode 0x06, followed by chip select rising after exactly 8 bits while no program cycle runs, sets `wel`. Chip select rising at any other bit count leaves `wel` unchanged.
- R3: Opcode 0x05 shifts out the status byte MSB first on `so`, one bit per falling serial clock, and repeats it for as long as chip select stays low. Bit 0 is the busy flag, bit 1 is the write-enable latch and bits 7:2 are 0. `so` is 0 while chip select is high. The status read is honoured during a program cycle.
- R4: Opcode 0x42 with an accepted address and at least one data byte, ended by chip select rising on a byte boundary, raises `wip` for exactly TPP_CYCLES clocks. `wel` clears on the same clock edge that `wip` falls.
- R5: Each programmed byte becomes old value AND new data. Bytes of the register that were not sent keep their value.
- R6: Address bits 7:0 give the first byte address. The address increments per byte and wraps from 0xFF to 0x00 inside the register. A later byte for the same address in one command replaces the earlier one, so at most the last 256 bytes take effect.
- R7: A program command issued while `wel` is 0 is ignored: no cycle starts and no register changes.
- R8: `lock_bits[k]` set to 1 makes register k+1 read-only. A program command aimed at that register is ignored and `wel` stays 1.
- R9: The address is accepted only when bits 23:16 are 0x00, bits 11:8 are 0000, and bits 15:12 are 1, 2 or 3, which select register 1, 2 or 3. Any other address is ignored and `wel` stays 1.
- R10: A program command whose chip select rises off a byte boundary, or before any full data byte, is ignored and `wel` stays 1.
- R11: While `wip` is 1, every command other than the status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, mode 0 (idle low) |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, sampled on rising sclk |
| so | output | 1 | Serial data out, updated on falling sclk |
| lock_bits | input | NUM_REGS | Permanent lock per security register |
| arr_rd_sel | input | SEL_W | Register index (0..2) for the read port |
| arr_rd_addr | input | ADDR_W | Byte address for the read port |
| arr_rd_data | output | 8 | Read data, one clock after the address |
| wip | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with TPP_CYCLES set to 1000 and keeps the default three 256-byte registers and two synchroniser stages. With a 1000-clock cycle, a status read and a complete second program command both fit inside one program cycle, so the busy gating can be observed at the ports. Because the registers are full size, the bench can send 258 bytes in one command, which exercises both the address wrap and the replacement of early bytes at the same addresses. A final sweep compares all 768 register bytes against the bench's own model.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam logic [7:0] OPC_PROG = 8'h42;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;

  typedef enum logic [2:0] {
    CS_OPC,
    CS_WEN,
    CS_ADDR,
    CS_DATA,
    CS_STAT,
    CS_SKIP
  } cmd_state_e;
endpackage

// File: rtl/secreg_link.sv
// Serial front end: synchronises the pins, assembles bytes, shifts status out.
module secreg_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       si,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       sel_start,
  output logic       sel_end,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       at_boundary,
  output logic       so
);
  logic [SYNC_STAGES-1:0] sclk_sr, csn_sr, si_sr;
  logic sclk_d, csn_d;
  logic sclk_s, csn_s, si_s;
  logic act, rise, fall;
  logic [2:0] bit_cnt, tx_idx;
  logic [6:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '0;
      csn_sr  <= '1;
      si_sr   <= '0;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
      csn_sr  <= {csn_sr[SYNC_STAGES-2:0], cs_n};
      si_sr   <= {si_sr[SYNC_STAGES-2:0], si};
      sclk_d  <= sclk_s;
      csn_d   <= csn_s;
    end
  end

  assign sclk_s = sclk_sr[SYNC_STAGES-1];
  assign csn_s  = csn_sr[SYNC_STAGES-1];
  assign si_s   = si_sr[SYNC_STAGES-1];
  assign act    = ~csn_s;
  assign rise   = act & sclk_s & ~sclk_d;
  assign fall   = act & ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      sel_start <= 1'b0;
      sel_end   <= 1'b0;
    end else begin
      sel_start <= csn_d & ~csn_s;
      sel_end   <= ~csn_d & csn_s;
      byte_vld  <= 1'b0;
      if (csn_d & ~csn_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg   <= {shreg[5:0], si_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, si_s};
        end
      end
    end
  end

  assign at_boundary = (bit_cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst || !act || !tx_en) begin
      tx_idx <= '0;
      so     <= 1'b0;
    end else if (fall) begin
      so     <= tx_byte[3'd7 - tx_idx];
      tx_idx <= tx_idx + 3'd1;
    end
  end

  a_r3_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    $rose(csn_s) |=> !so);
  a_r10_byte_on_boundary: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> at_boundary);
endmodule

// File: rtl/secreg_cmd.sv
// Command decoder: opcode, address check, data staging, end-of-frame decisions.
module secreg_cmd
  import secreg_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int ADDR_W   = 8,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_start,
  input  logic                sel_end,
  input  logic                byte_vld,
  input  logic [7:0]          byte_data,
  input  logic                at_boundary,
  input  logic                busy,
  input  logic                wel,
  input  logic [NUM_REGS-1:0] lock_bits,
  output logic                tx_en,
  output logic                wren_pulse,
  output logic                prog_pulse,
  output logic [SEL_W-1:0]    prog_sel,
  output logic                stg_clear,
  output logic                stg_we,
  output logic [ADDR_W-1:0]   stg_addr,
  output logic [7:0]          stg_data
);
  cmd_state_e         state;
  logic [15:0]        addr_sh;
  logic [1:0]         addr_cnt;
  logic [ADDR_W-1:0]  ptr;
  logic [SEL_W-1:0]   sel_q;
  logic               got_data;

  logic [23:0]        addr_full;
  logic [3:0]         fld;
  logic               fld_ok, addr_ok;
  logic [SEL_W-1:0]   fld_sel;

  // Address acceptance: zero upper byte, zero gap bits, register field 1..NUM_REGS, unlocked
  assign addr_full = {addr_sh, byte_data};
  assign fld       = addr_full[15:12];
  assign fld_ok    = (fld != 4'd0) && (int'(fld) <= NUM_REGS);
  assign fld_sel   = SEL_W'(fld - 4'd1);
  assign addr_ok   = (addr_full[23:16] == 8'h00) && (addr_full[11:ADDR_W] == '0) &&
                     fld_ok && !lock_bits[fld_sel];

  assign tx_en = (state == CS_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CS_SKIP;
      addr_sh    <= '0;
      addr_cnt   <= '0;
      ptr        <= '0;
      sel_q      <= '0;
      got_data   <= 1'b0;
      wren_pulse <= 1'b0;
      prog_pulse <= 1'b0;
      prog_sel   <= '0;
      stg_clear  <= 1'b0;
      stg_we     <= 1'b0;
      stg_addr   <= '0;
      stg_data   <= '0;
    end else begin
      wren_pulse <= 1'b0;
      prog_pulse <= 1'b0;
      stg_clear  <= 1'b0;
      stg_we     <= 1'b0;
      if (sel_start) begin
        state    <= CS_OPC;
        addr_cnt <= '0;
        got_data <= 1'b0;
      end else if (sel_end) begin
        if (state == CS_WEN && at_boundary && !busy) wren_pulse <= 1'b1;
        if (state == CS_DATA && got_data && at_boundary && !busy) begin
          prog_pulse <= 1'b1;
          prog_sel   <= sel_q;
        end
        state <= CS_SKIP;
      end else if (byte_vld) begin
        unique case (state)
          CS_OPC: begin
            if (byte_data == OPC_RDSR)                    state <= CS_STAT;
            else if (busy)                                state <= CS_SKIP;
            else if (byte_data == OPC_WREN)               state <= CS_WEN;
            else if (byte_data == OPC_PROG && wel)        state <= CS_ADDR;
            else                                          state <= CS_SKIP;
          end
          CS_WEN: state <= CS_SKIP;
          CS_ADDR: begin
            addr_sh  <= {addr_sh[7:0], byte_data};
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'd2) begin
              if (addr_ok) begin
                state     <= CS_DATA;
                ptr       <= addr_full[ADDR_W-1:0];
                sel_q     <= fld_sel;
                stg_clear <= 1'b1;
              end else begin
                state <= CS_SKIP;
              end
            end
          end
          CS_DATA: begin
            stg_we   <= 1'b1;
            stg_addr <= ptr;
            stg_data <= byte_data;
            ptr      <= ptr + 1'b1;
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_wren_only_idle: assert property (@(posedge clk) disable iff (rst)
    wren_pulse |-> !busy);
  a_r6_stage_only_in_data: assert property (@(posedge clk) disable iff (rst)
    stg_we |-> (state == CS_DATA));
endmodule

// File: rtl/secreg_stage.sv
// Staging buffer: one byte per register address plus a written-flag per byte.
module secreg_stage #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  logic [7:0]       ram [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (we)      vld[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= vld[raddr];
  end
endmodule

// File: rtl/secreg_mem.sv
// Security register storage: one write port, two synchronous read ports.
module secreg_mem #(
  parameter int NUM_REGS  = 3,
  parameter int REG_BYTES = 256,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [SEL_W-1:0]  rsel_a,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [SEL_W-1:0]  rsel_b,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  localparam int DEPTH  = NUM_REGS * REG_BYTES;
  localparam int FLAT_W = $clog2(DEPTH);

  logic [7:0] ram [DEPTH];

  function automatic logic [FLAT_W-1:0] flat(input logic [SEL_W-1:0] s, input logic [ADDR_W-1:0] a);
    return FLAT_W'(s) * FLAT_W'(REG_BYTES) + FLAT_W'(a);
  endfunction

  // Erased cells read as all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) ram[flat(wsel, waddr)] <= wdata;
    rdata_a <= ram[flat(rsel_a, raddr_a)];
    rdata_b <= ram[flat(rsel_b, raddr_b)];
  end
endmodule

// File: rtl/secreg_prog.sv
module secreg_prog #(
  parameter int NUM_REGS    = 3,
  parameter int REG_BYTES   = 256,
  parameter int TPP_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(REG_BYTES),
  localparam int SEL_W      = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                si,
  output logic                so,
  input  logic [NUM_REGS-1:0] lock_bits,
  input  logic [SEL_W-1:0]    arr_rd_sel,
  input  logic [ADDR_W-1:0]   arr_rd_addr,
  output logic [7:0]          arr_rd_data,
  output logic                wip,
  output logic                wel
);
  // TPP_CYCLES must be at least REG_BYTES + 2 so the merge walk ends inside the cycle
  localparam int CNT_W = $clog2(TPP_CYCLES + 1);

  logic              sel_start, sel_end, byte_vld, at_boundary;
  logic [7:0]        byte_data;
  logic              tx_en, wren_pulse, prog_pulse;
  logic [SEL_W-1:0]  prog_sel;
  logic              stg_clear, stg_we, stg_rvalid;
  logic [ADDR_W-1:0] stg_addr;
  logic [7:0]        stg_data, stg_rdata;
  logic [7:0]        mem_b_q, status_byte;

  logic              wip_q, wel_q;
  logic [CNT_W-1:0]  tpp_cnt;
  logic [SEL_W-1:0]  eng_sel;
  logic [ADDR_W:0]   walk_idx;
  logic              walk_done, pend, mem_we;
  logic [ADDR_W-1:0] pend_addr;

  assign status_byte = {6'b0, wel_q, wip_q};

  secreg_link #(.SYNC_STAGES(SYNC_STAGES)) link_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si),
    .tx_en(tx_en), .tx_byte(status_byte),
    .sel_start(sel_start), .sel_end(sel_end), .byte_vld(byte_vld),
    .byte_data(byte_data), .at_boundary(at_boundary), .so(so)
  );

  secreg_cmd #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) cmd_i (
    .clk(clk), .rst(rst), .sel_start(sel_start), .sel_end(sel_end),
    .byte_vld(byte_vld), .byte_data(byte_data), .at_boundary(at_boundary),
    .busy(wip_q), .wel(wel_q), .lock_bits(lock_bits), .tx_en(tx_en),
    .wren_pulse(wren_pulse), .prog_pulse(prog_pulse), .prog_sel(prog_sel),
    .stg_clear(stg_clear), .stg_we(stg_we), .stg_addr(stg_addr), .stg_data(stg_data)
  );

  secreg_stage #(.DEPTH(REG_BYTES), .ADDR_W(ADDR_W)) stage_i (
    .clk(clk), .rst(rst), .clear(stg_clear), .we(stg_we), .waddr(stg_addr),
    .wdata(stg_data), .raddr(walk_idx[ADDR_W-1:0]), .rdata(stg_rdata), .rvalid(stg_rvalid)
  );

  secreg_mem #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) mem_i (
    .clk(clk), .we(mem_we), .wsel(eng_sel), .waddr(pend_addr), .wdata(mem_b_q & stg_rdata),
    .rsel_a(arr_rd_sel), .raddr_a(arr_rd_addr), .rdata_a(arr_rd_data),
    .rsel_b(eng_sel), .raddr_b(walk_idx[ADDR_W-1:0]), .rdata_b(mem_b_q)
  );

  // Program engine: timed busy window plus a read-AND-write walk over the staged bytes
  assign walk_done = walk_idx[ADDR_W];
  assign mem_we    = pend & stg_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wip_q     <= 1'b0;
      wel_q     <= 1'b0;
      tpp_cnt   <= '0;
      eng_sel   <= '0;
      walk_idx  <= (ADDR_W+1)'(REG_BYTES);
      pend      <= 1'b0;
      pend_addr <= '0;
    end else begin
      pend      <= wip_q & ~walk_done;
      pend_addr <= walk_idx[ADDR_W-1:0];
      if (prog_pulse) begin
        wip_q    <= 1'b1;
        tpp_cnt  <= '0;
        eng_sel  <= prog_sel;
        walk_idx <= '0;
      end else if (wip_q) begin
        tpp_cnt <= tpp_cnt + 1'b1;
        if (!walk_done) walk_idx <= walk_idx + 1'b1;
        if (tpp_cnt == CNT_W'(TPP_CYCLES - 1)) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end
      end else if (wren_pulse) begin
        wel_q <= 1'b1;
      end
    end
  end

  assign wip = wip_q;
  assign wel = wel_q;

  a_r4_cycle_from_command: assert property (@(posedge clk) disable iff (rst)
    $rose(wip_q) |-> $past(prog_pulse));
  a_r4_wel_cleared_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(wip_q) |-> !wel_q);
  a_r7_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
    prog_pulse |-> wel_q);
  a_r8_start_unlocked: assert property (@(posedge clk) disable iff (rst)
    prog_pulse |-> !lock_bits[prog_sel]);
  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    prog_pulse |-> !wip_q);
  a_r5_write_inside_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wip_q);
endmodule

// File: tb/secreg_prog_tb.sv
`timescale 1ns/1ps
module secreg_prog_tb_top;
  localparam int NREG  = 3;
  localparam int NBYTE = 256;
  localparam int TPP   = 1000;
  localparam int H     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, wip, wel;
  logic [2:0] lock_bits = 3'b000;
  logic [1:0] arr_rd_sel = 2'd0;
  logic [7:0] arr_rd_addr = 8'd0;
  logic [7:0] arr_rd_data;

  always #2.5 clk = ~clk;

  secreg_prog #(.TPP_CYCLES(TPP)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si), .so(so),
    .lock_bits(lock_bits), .arr_rd_sel(arr_rd_sel), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .wip(wip), .wel(wel)
  );

  int n_checks = 0, n_fail = 0;
  int rises = 0, run = 0;
  bit prev_wip = 1'b0, done = 1'b0, wel_m = 1'b0;
  logic [7:0] exp_mem [NREG][NBYTE];
  logic [7:0] pay [0:299];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Every-clock monitor of the busy window
  always @(negedge clk) begin
    if (rst) begin
      run = 0; prev_wip = 1'b0;
    end else begin
      if (wip) run++;
      else if (prev_wip) begin
        chk(run == TPP, "R4", "busy window length", run, TPP);
        chk(wel == 1'b0, "R4", "wel at busy end", int'(wel), 0);
        run = 0;
      end
      if (wip && !prev_wip) rises++;
      prev_wip = wip;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = b[i]; sclk = 1'b0; tick(H); sclk = 1'b1; tick(H);
    end
  endtask

  task automatic send_byte(input logic [7:0] b); send_bits(b, 8); endtask
  task automatic sel_on(); cs_n = 1'b0; tick(H); endtask
  task automatic sel_off(); tick(H); cs_n = 1'b1; tick(H); sclk = 1'b0; tick(2*H); endtask

  task automatic read_status(output logic [7:0] st);
    sel_on(); send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; tick(H); sclk = 1'b1; tick(H); st[i] = so;
    end
    sel_off();
  endtask

  task automatic rd_arr(input int s, input int a, output logic [7:0] d);
    arr_rd_sel = 2'(s); arr_rd_addr = 8'(a); tick(1); d = arr_rd_data;
  endtask

  task automatic do_wren();
    sel_on(); send_byte(8'h06); sel_off(); wel_m = 1'b1;
    chk(wel == 1'b1, "R2", "wel after write enable", int'(wel), 1);
  endtask

  task automatic wait_idle(); while (wip) tick(1); endtask

  task automatic do_prog(input logic [23:0] a, input int n, input int extra, input string req);
    int fld, r0, idx;
    bit acc;
    logic [7:0] t [NBYTE];
    bit v [NBYTE];
    fld = int'(a[15:12]);
    acc = wel_m && a[23:16] == 8'h00 && a[11:8] == 4'h0 && fld >= 1 && fld <= NREG &&
          n >= 1 && extra == 0;
    if (acc) acc = !lock_bits[fld-1];
    r0 = rises;
    sel_on();
    send_byte(8'h42); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int k = 0; k < n; k++) send_byte(pay[k]);
    if (extra > 0) send_bits(8'h00, extra);
    sel_off();
    if (acc) begin
      chk(wip == 1'b1, req, "program cycle started", int'(wip), 1);
      for (int k = 0; k < NBYTE; k++) v[k] = 1'b0;
      for (int k = 0; k < n; k++) begin
        idx = (int'(a[7:0]) + k) % NBYTE;
        t[idx] = pay[k]; v[idx] = 1'b1;
      end
      for (int k = 0; k < NBYTE; k++)
        if (v[k]) exp_mem[fld-1][k] = exp_mem[fld-1][k] & t[k];
      wait_idle(); tick(2);
      wel_m = 1'b0;
      chk(rises == r0 + 1, req, "one program cycle", rises - r0, 1);
    end else begin
      tick(8);
      chk(wip == 1'b0, req, "no cycle for ignored command", int'(wip), 0);
      chk(rises == r0, req, "no busy pulse", rises - r0, 0);
      chk(wel == wel_m, req, "wel unchanged", int'(wel), int'(wel_m));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    for (int s = 0; s < NREG; s++) for (int k = 0; k < NBYTE; k++) exp_mem[s][k] = 8'hFF;
    tick(5); rst = 1'b0; tick(2);

    // R1: reset state
    chk(wip == 1'b0, "R1", "wip after reset", int'(wip), 0);
    chk(wel == 1'b0, "R1", "wel after reset", int'(wel), 0);
    chk(so == 1'b0, "R1", "so after reset", int'(so), 0);
    rd_arr(1, 8'h77, d);
    chk(d == 8'hFF, "R1", "erased byte", d, 8'hFF);

    // R3: idle status
    read_status(st);
    chk(st == 8'h00, "R3", "status idle", st, 8'h00);

    // R2: write enable with a trailing partial byte is ignored
    sel_on(); send_byte(8'h06); send_bits(8'h00, 3); sel_off();
    chk(wel == 1'b0, "R2", "wel after misframed enable", int'(wel), 0);
    do_wren();
    read_status(st);
    chk(st == 8'h02, "R3", "status with wel", st, 8'h02);

    // R4 R5: first program of register 1
    pay[0] = 8'hA5; pay[1] = 8'h3C;
    do_prog(24'h001010, 2, 0, "R4");
    chk(wel == 1'b0, "R4", "wel after cycle", int'(wel), 0);
    rd_arr(0, 8'h10, d); chk(d == 8'hA5, "R5", "byte 0x10", d, 8'hA5);
    rd_arr(0, 8'h11, d); chk(d == 8'h3C, "R5", "byte 0x11", d, 8'h3C);
    rd_arr(0, 8'h12, d); chk(d == 8'hFF, "R5", "untouched byte", d, 8'hFF);

    // R5: bits can only be cleared
    do_wren(); pay[0] = 8'h0F;
    do_prog(24'h001010, 1, 0, "R5");
    rd_arr(0, 8'h10, d); chk(d == 8'h05, "R5", "AND merge", d, 8'h05);

    // R6: wrap inside register 3
    do_wren(); pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
    do_prog(24'h0030FE, 3, 0, "R6");
    rd_arr(2, 8'hFF, d); chk(d == 8'h22, "R6", "byte before wrap", d, 8'h22);
    rd_arr(2, 8'h00, d); chk(d == 8'h33, "R6", "wrapped byte", d, 8'h33);

    // R6: more than 256 bytes, later bytes replace earlier ones
    do_wren();
    for (int k = 0; k < 258; k++) pay[k] = 8'hFF;
    pay[0] = 8'h00; pay[1] = 8'h00; pay[256] = 8'hE7; pay[257] = 8'h7E;
    do_prog(24'h002000, 258, 0, "R6");
    rd_arr(1, 0, d); chk(d == 8'hE7, "R6", "replaced byte 0", d, 8'hE7);
    rd_arr(1, 1, d); chk(d == 8'h7E, "R6", "replaced byte 1", d, 8'h7E);

    // R7: no write enable
    pay[0] = 8'h00;
    do_prog(24'h002005, 1, 0, "R7");
    rd_arr(1, 5, d); chk(d == 8'hFF, "R7", "byte kept", d, 8'hFF);

    // R8: locked register 2
    lock_bits = 3'b010; do_wren();
    do_prog(24'h002005, 1, 0, "R8");
    rd_arr(1, 5, d); chk(d == 8'hFF, "R8", "locked byte kept", d, 8'hFF);

    // R9: rejected addresses (wel stays set)
    do_prog(24'h011005, 1, 0, "R9");
    do_prog(24'h001105, 1, 0, "R9");
    do_prog(24'h004005, 1, 0, "R9");
    do_prog(24'h000005, 1, 0, "R9");
    rd_arr(0, 5, d); chk(d == 8'hFF, "R9", "byte kept", d, 8'hFF);

    // R10: chip select off a byte boundary, and with no data byte
    do_prog(24'h001020, 1, 4, "R10");
    do_prog(24'h001020, 0, 0, "R10");
    rd_arr(0, 8'h20, d); chk(d == 8'hFF, "R10", "byte kept", d, 8'hFF);

    // R8: unlocking lets register 2 program
    lock_bits = 3'b000; pay[0] = 8'h5A;
    do_prog(24'h002005, 1, 0, "R8");
    rd_arr(1, 5, d); chk(d == 8'h5A, "R8", "unlocked write", d, 8'h5A);

    // R11 R3: commands while busy
    begin
      int r0;
      do_wren(); r0 = rises;
      sel_on(); send_byte(8'h42); send_byte(8'h00); send_byte(8'h10); send_byte(8'h30);
      send_byte(8'h00); sel_off();
      chk(wip == 1'b1, "R11", "cycle running", int'(wip), 1);
      read_status(st);
      chk(st == 8'h03, "R3", "status while busy", st, 8'h03);
      sel_on(); send_byte(8'h42); send_byte(8'h00); send_byte(8'h10); send_byte(8'h31);
      send_byte(8'h00); sel_off();
      wait_idle(); tick(8);
      chk(rises == r0 + 1, "R11", "single cycle", rises - r0, 1);
      exp_mem[0][8'h30] = 8'h00; wel_m = 1'b0;
      rd_arr(0, 8'h31, d); chk(d == 8'hFF, "R11", "busy command ignored", d, 8'hFF);
    end

    // R5: full comparison against the model
    for (int s = 0; s < NREG; s++)
      for (int k = 0; k < NBYTE; k++) begin
        rd_arr(s, k, d);
        chk(d == exp_mem[s][k], "R5", "array sweep", d, exp_mem[s][k]);
      end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule